// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the controller side of the two-wire PHY management bus. A host issues one request at a time: a PHY number, a register number or a 21-bit extended address, write data, a read/write select and an extended-frame select. The block generates the management clock from the system clock. It drives the data line through an output-enable meant for a tri-state pad and samples the line during the read phase. It builds every frame bit by bit: preamble, start code, opcode, both address fields, turnaround and the 16-bit payload.

An extended-address access takes two frames. The first is an address frame that carries the low 16 address bits. The second is the read or write frame, and it carries the device number in its register field. On reads the block checks the turnaround bit that the PHY returns. A per-PHY mask lets the check be waived for PHYs that do not drive that bit correctly. When the check fails, the block clocks out 32 further bits, discards them and reports all ones together with an error flag.

The clock half-period and the read sampling point are parameters counted in system clock cycles (`HALF_CYC`, `SMP_DLY`, with `SMP_DLY < HALF_CYC`).

Top module: `mdio_master`

## Requirements
- R1: After reset, and between transactions, `mdc` is low, `mdio_oe` is low, `busy` is low and `done` is low.
- R2: A request (`req_valid` high for a cycle) is taken only while `busy` is low, and `busy` is high from the next cycle on. A `req_valid` pulse while `busy` is high has no effect on the frame on the wire or on the result.
- R3: Each bit lasts `2*HALF_CYC` system cycles: `HALF_CYC` with `mdc` low followed by `HALF_CYC` with `mdc` high. The `done` pulse arrives exactly (number of bits on the wire) × `2*HALF_CYC` cycles after the accepting clock edge.
- R4: `mdio_o` and `mdio_oe` change only while `mdc` is low, and never during a high half.
- R5: Every frame opens with 32 driven 1 bits.
- R6: A plain (non-extended) frame sends start code 0,1, then opcode 1,0 for read or 0,1 for write, then `req_phy` (5 bits) and `req_addr[4:0]` (5 bits), each MSB first.
- R7: An extended access first sends an address frame: start 0,0, opcode 0,0, PHY, device number `req_addr[20:16]`, turnaround 1,0, `req_addr[15:0]` MSB first, and one released bit. Then it sends start 0,0 with opcode 1,1 (read) or 0,1 (write), the PHY and the device number in the register field.
- R8: On a write frame the block drives turnaround 1,0 and 16 data bits MSB first, then releases the line (`mdio_oe` low) for one bit.
- R9: On a read frame the line is released right after the register field. One turnaround bit is sampled, then 16 data bits (MSB first), then one more released bit follows. `done` returns the 16 bits on `rd_data` with `ta_err` low.
- R10: If the sampled turnaround bit is 1 and `ta_ignore[req_phy]` is 0, the block clocks 32 more released bits, and `done` comes with `rd_data` = 0xFFFF and `ta_err` = 1.
- R11: If `ta_ignore[req_phy]` is 1, a turnaround bit of 1 is disregarded and the read proceeds as in R9.
- R12: Each read bit is sampled `SMP_DLY` system cycles after the rising `mdc` edge. A value that becomes valid only at that cycle and stays valid until `mdc` falls is captured correctly.
- R13: `done` is a single-cycle pulse during which `busy` is already low. A write returns `rd_data` = 0 and `ta_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | 1 = extended-address access (two frames) |
| req_phy | input | 5 | PHY number |
| req_addr | input | 21 | Register number in [4:0], or device [20:16] and register [15:0] |
| req_wdata | input | 16 | Write data |
| ta_ignore | input | 32 | Per-PHY waiver of the turnaround check |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| ta_err | output | 1 | Turnaround failure, valid with done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value to the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data value from the pad |

## Verification
The assertions assume that the request fields are only meaningful on the cycle `req_valid` is taken. They also assume that `ta_ignore` stays constant during a transaction. The bench sets the mask only between transactions and varies the request fields only during the deliberate busy-time poke. The sampling checks assume the PHY's value is settled from `SMP_DLY` cycles after the rising edge until the falling edge. The bench's PHY model drives the inverted value for the first part of each high half and the true value only from that cycle on.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 16;
    localparam int DEV_W     = 5;
    localparam int XADDR_W   = DEV_W + DATA_W;
    localparam int PHY_CNT   = 1 << PHY_W;
    localparam int PRE_LEN   = 32;
    localparam int FLUSH_LEN = 32;
    localparam int HDR_BITS  = PRE_LEN + 4 + PHY_W + REG_W;
    localparam int FRAME_W   = HDR_BITS + 2 + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    localparam logic [1:0] ST_STD  = 2'b01;
    localparam logic [1:0] ST_EXT  = 2'b00;
    localparam logic [1:0] TA_DRV  = 2'b10;

    typedef enum logic [1:0] {
        FK_ADDR = 2'd0,
        FK_WR   = 2'd1,
        FK_RD   = 2'd2
    } frame_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DRIVE = 3'd1,
        PH_TURN  = 3'd2,
        PH_RECV  = 3'd3,
        PH_FLUSH = 3'd4,
        PH_REL   = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [FRAME_W-1:0]  sreg;
        logic [CNT_W-1:0]    cnt;
        logic                pend;
        logic                is_wr;
        logic                cur_rd;
        logic [PHY_W-1:0]    phy;
        logic [DEV_W-1:0]    dev;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                samp;
        logic                ta_err;
        logic                busy;
        logic                done;
        logic                oe;
        logic                run;
    } seq_state_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_CYC = 16,
    parameter int SMP_DLY  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic bit_end,
    output logic sample_stb
);
    localparam int PER = 2 * HALF_CYC;
    localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          mdc_d, mdc_q;

    always_comb begin
        if (run) begin
            cnt_d = (cnt_q == CW'(PER - 1)) ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
        mdc_d = run && (cnt_d >= CW'(HALF_CYC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            mdc_q <= mdc_d;
        end
    end

    assign mdc        = mdc_q;
    assign bit_end    = run && (cnt_q == CW'(PER - 1));
    assign sample_stb = run && (cnt_q == CW'(HALF_CYC + SMP_DLY));

    // independent run-length counters for the half-period checks
    logic [CW:0] hi_d, hi_q, lo_d, lo_q;

    always_comb begin
        hi_d = mdc_q ? hi_q + 1'b1 : '0;
        lo_d = (run && !mdc_q) ? lo_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    a_r3_high_half: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc_q) |-> hi_q == (CW+1)'(HALF_CYC))
        else $error("mdc high half has wrong length");

    a_r3_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_q) |-> lo_q == (CW+1)'(HALF_CYC))
        else $error("mdc low half has wrong length");

endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
    import mdio_pkg::*;
(
    input  logic               ext,
    input  frame_kind_e        kind,
    input  logic [PHY_W-1:0]   phy,
    input  logic [REG_W-1:0]   regf,
    input  logic [DATA_W-1:0]  word,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   len
);
    logic [1:0] st;
    logic [1:0] op;

    always_comb begin
        st = ext ? ST_EXT : ST_STD;
        unique case (kind)
            FK_ADDR: op = 2'b00;
            FK_WR:   op = 2'b01;
            FK_RD:   op = ext ? 2'b11 : 2'b10;
            default: op = 2'b00;
        endcase
        frame = {{PRE_LEN{1'b1}}, st, op, phy, regf, TA_DRV, word};
        len   = (kind == FK_RD) ? CNT_W'(HDR_BITS) : CNT_W'(FRAME_W);
    end

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_c45,
    input  logic [PHY_W-1:0]   req_phy,
    input  logic [XADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [PHY_CNT-1:0] ta_ignore,
    input  logic               mdio_i,
    input  logic               bit_end,
    input  logic               sample_stb,
    output logic               run,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               ta_err
);
    seq_state_t q, d;

    frame_kind_e        k1, k2;
    logic [REG_W-1:0]   r1;
    logic [DATA_W-1:0]  w1;
    logic [FRAME_W-1:0] f1, f2;
    logic [CNT_W-1:0]   l1, l2;
    logic               ta_bit;

    always_comb begin
        if (req_c45) begin
            k1 = FK_ADDR;
            r1 = req_addr[XADDR_W-1:DATA_W];
            w1 = req_addr[DATA_W-1:0];
        end else begin
            k1 = req_write ? FK_WR : FK_RD;
            r1 = req_addr[REG_W-1:0];
            w1 = req_wdata;
        end
        k2 = q.is_wr ? FK_WR : FK_RD;
    end

    mdio_frame_fmt u_fmt_first (
        .ext   (req_c45),
        .kind  (k1),
        .phy   (req_phy),
        .regf  (r1),
        .word  (w1),
        .frame (f1),
        .len   (l1)
    );

    mdio_frame_fmt u_fmt_second (
        .ext   (1'b1),
        .kind  (k2),
        .phy   (q.phy),
        .regf  (q.dev),
        .word  (q.wdata),
        .frame (f2),
        .len   (l2)
    );

    assign ta_bit = sample_stb ? mdio_i : q.samp;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    d.phase  = PH_DRIVE;
                    d.busy   = 1'b1;
                    d.run    = 1'b1;
                    d.oe     = 1'b1;
                    d.sreg   = f1;
                    d.cnt    = l1;
                    d.pend   = req_c45;
                    d.is_wr  = req_write;
                    d.cur_rd = !req_c45 && !req_write;
                    d.phy    = req_phy;
                    d.dev    = req_addr[XADDR_W-1:DATA_W];
                    d.wdata  = req_wdata;
                    d.rdata  = '0;
                    d.ta_err = 1'b0;
                end
            end
            PH_DRIVE: begin
                if (bit_end) begin
                    d.sreg = {q.sreg[FRAME_W-2:0], 1'b1};
                    d.cnt  = q.cnt - 1'b1;
                    if (q.cnt == CNT_W'(1)) begin
                        d.oe    = 1'b0;
                        d.phase = q.cur_rd ? PH_TURN : PH_REL;
                    end
                end
            end
            PH_TURN: begin
                if (sample_stb) begin
                    d.samp = mdio_i;
                end
                if (bit_end) begin
                    if (ta_bit && !ta_ignore[q.phy]) begin
                        d.phase  = PH_FLUSH;
                        d.cnt    = CNT_W'(FLUSH_LEN);
                        d.ta_err = 1'b1;
                    end else begin
                        d.phase = PH_RECV;
                        d.cnt   = CNT_W'(DATA_W);
                    end
                end
            end
            PH_RECV: begin
                if (sample_stb) begin
                    d.rdata = {q.rdata[DATA_W-2:0], mdio_i};
                end
                if (bit_end) begin
                    d.cnt = q.cnt - 1'b1;
                    if (q.cnt == CNT_W'(1)) begin
                        d.phase = PH_REL;
                    end
                end
            end
            PH_FLUSH: begin
                if (bit_end) begin
                    d.cnt = q.cnt - 1'b1;
                    if (q.cnt == CNT_W'(1)) begin
                        d.rdata = '1;
                        d.phase = PH_IDLE;
                        d.busy  = 1'b0;
                        d.run   = 1'b0;
                        d.done  = 1'b1;
                    end
                end
            end
            PH_REL: begin
                if (bit_end) begin
                    if (q.pend) begin
                        d.pend   = 1'b0;
                        d.phase  = PH_DRIVE;
                        d.oe     = 1'b1;
                        d.sreg   = f2;
                        d.cnt    = l2;
                        d.cur_rd = !q.is_wr;
                    end else begin
                        d.phase = PH_IDLE;
                        d.busy  = 1'b0;
                        d.run   = 1'b0;
                        d.done  = 1'b1;
                    end
                end
            end
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run     = q.run;
    assign mdio_o  = q.sreg[FRAME_W-1];
    assign mdio_oe = q.oe;
    assign busy    = q.busy;
    assign done    = q.done;
    assign rd_data = q.rdata;
    assign ta_err  = q.ta_err;

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !run)
        else $error("done while still busy");

    a_r10_flush_ones: assert property (@(posedge clk) disable iff (!rst_n)
        done && ta_err |-> rd_data == '1)
        else $error("turnaround failure without all-ones data");

    a_r9_released_on_input: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_TURN || q.phase == PH_RECV || q.phase == PH_FLUSH) |-> !mdio_oe)
        else $error("line driven while receiving");

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC = 16,
    parameter int SMP_DLY  = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_c45,
    input  logic [4:0]          req_phy,
    input  logic [20:0]         req_addr,
    input  logic [15:0]         req_wdata,
    input  logic [31:0]         ta_ignore,
    output logic                busy,
    output logic                done,
    output logic [15:0]         rd_data,
    output logic                ta_err,
    output logic                mdc,
    output logic                mdio_o,
    output logic                mdio_oe,
    input  logic                mdio_i
);
    logic run, bit_end, sample_stb;

    mdio_clkgen #(
        .HALF_CYC (HALF_CYC),
        .SMP_DLY  (SMP_DLY)
    ) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mdc        (mdc),
        .bit_end    (bit_end),
        .sample_stb (sample_stb)
    );

    mdio_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_c45    (req_c45),
        .req_phy    (req_phy),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ta_ignore  (ta_ignore),
        .mdio_i     (mdio_i),
        .bit_end    (bit_end),
        .sample_stb (sample_stb),
        .run        (run),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data),
        .ta_err     (ta_err)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe)
        else $error("bus active while idle");

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy |=> busy)
        else $error("request not taken");

    a_r4_mdio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o) && $stable(mdio_oe))
        else $error("data line changed while mdc high");

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int HALF = 4;
    localparam int SDLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_c45 = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [31:0] ta_mask = '0;
    logic        busy, done, ta_err, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio_master #(.HALF_CYC(HALF), .SMP_DLY(SDLY)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_c45(req_c45), .req_phy(req_phy), .req_addr(req_addr),
        .req_wdata(req_wdata), .ta_ignore(ta_mask), .busy(busy), .done(done),
        .rd_data(rd_data), .ta_err(ta_err), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int tot = 0;
    int bad = 0;
    int cyc = 0;
    bit fin = 0;

    logic  exp_oe [0:255];
    logic  exp_o  [0:255];
    logic  resp   [0:255];
    string exp_tag[0:255];
    int    nexp;
    logic  rec_oe [0:255];
    logic  rec_o  [0:255];
    int    nrec = 0;
    int    base_g = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!fin) begin
            fin = 1;
            $display("test done: total=%0d bad=%0d", tot, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !fin) begin
            tot++;
            bad++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 190000);
            report();
        end
    end

    // PHY model: record at every rising mdc, drive the wrong value first,
    // the right value from SDLY system cycles after the edge (R12)
    int midx;
    always @(posedge mdc) begin
        midx = nrec - base_g;
        if (midx >= 0 && midx < 256) begin
            rec_oe[midx] = mdio_oe;
            rec_o[midx]  = mdio_o;
        end
        nrec++;
        mdio_i <= (midx >= 0 && midx < 256) ? ~resp[midx] : 1'b1;
        repeat (SDLY) @(posedge clk);
        mdio_i <= (midx >= 0 && midx < 256) ? resp[midx] : 1'b1;
    end

    // R4: outputs held during the whole high half
    int hidx;
    always @(negedge clk) begin
        if (rst_n && mdc) begin
            hidx = nrec - base_g - 1;
            if (hidx >= 0 && hidx < 256)
                chk(mdio_oe == rec_oe[hidx] && (!mdio_oe || mdio_o == rec_o[hidx]),
                    "R4 hold", {30'd0, mdio_oe, mdio_o}, {30'd0, rec_oe[hidx], rec_o[hidx]});
        end
    end

    task automatic push(input logic oe, input logic o, input logic r, input string tag);
        exp_oe[nexp] = oe; exp_o[nexp] = o; resp[nexp] = r; exp_tag[nexp] = tag;
        nexp++;
    endtask

    task automatic push_num(input logic [15:0] v, input int w, input string tag);
        for (int i = w - 1; i >= 0; i--) push(1'b1, v[i], 1'b1, tag);
    endtask

    task automatic add_frame(input bit ext, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] regf, input bit rd, input logic [15:0] word,
                             input bit ta_bad, input logic [15:0] rdv, input bit ign,
                             input string dtag);
        string htag;
        htag = ext ? "R7" : "R6";
        for (int i = 0; i < 32; i++) push(1'b1, 1'b1, 1'b1, "R5");
        push(1'b1, 1'b0, 1'b1, htag);
        push(1'b1, ext ? 1'b0 : 1'b1, 1'b1, htag);
        push_num({14'd0, op}, 2, htag);
        push_num({11'd0, phy}, 5, htag);
        push_num({11'd0, regf}, 5, htag);
        if (!rd) begin
            push(1'b1, 1'b1, 1'b1, dtag);
            push(1'b1, 1'b0, 1'b1, dtag);
            push_num(word, 16, dtag);
            push(1'b0, 1'b0, 1'b1, dtag);
        end else begin
            push(1'b0, 1'b0, ta_bad, "R9");
            if (ta_bad && !ign) begin
                for (int i = 0; i < 32; i++) push(1'b0, 1'b0, 1'((i * 5) % 3 == 0), "R10");
            end else begin
                for (int i = 15; i >= 0; i--) push(1'b0, 1'b0, rdv[i], "R12");
                push(1'b0, 1'b0, 1'b1, "R9");
            end
        end
    endtask

    task automatic do_txn(input bit wr, input bit ext, input logic [4:0] phy,
                          input logic [20:0] addr, input logic [15:0] wd,
                          input bit ta_bad, input logic [15:0] rdv, input bit poke);
        bit ign, fail;
        int c;
        bit got;
        logic [15:0] exp_rd;
        int n;
        ign = ta_mask[phy];
        fail = !wr && ta_bad && !ign;
        nexp = 0;
        if (ext) begin
            add_frame(1'b1, 2'b00, phy, addr[20:16], 1'b0, addr[15:0], 1'b0, 16'h0, ign, "R7");
            add_frame(1'b1, wr ? 2'b01 : 2'b11, phy, addr[20:16], !wr, wd, ta_bad, rdv, ign,
                      "R8");
        end else begin
            add_frame(1'b0, wr ? 2'b01 : 2'b10, phy, addr[4:0], !wr, wd, ta_bad, rdv, ign, "R8");
        end
        exp_rd = wr ? 16'h0000 : (fail ? 16'hFFFF : rdv);

        @(negedge clk);
        base_g = nrec;
        req_write = wr; req_c45 = ext; req_phy = phy; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        c = 0;
        got = 0;
        while (!got && c < 3000) begin
            @(negedge clk);
            c++;
            if (c == 1) chk(busy === 1'b1, "R2 busy after accept", {31'd0, busy}, 1);
            req_valid = poke && (c == 20);
            if (poke && c == 20) begin
                req_write = ~wr; req_c45 = ~ext; req_phy = ~phy; req_addr = ~addr;
                req_wdata = ~wd;
            end
            if (done) got = 1;
        end
        req_valid = 1'b0;
        chk(got, "R13 done seen", {31'd0, got}, 1);
        chk(c == nexp * 2 * HALF + 1, "R3 duration", c, nexp * 2 * HALF + 1);
        chk(busy === 1'b0, "R13 busy low at done", {31'd0, busy}, 0);
        chk(rd_data === exp_rd, wr ? "R13 write rd_data" : (fail ? "R10 rd_data" :
            (ign && ta_bad ? "R11 rd_data" : "R9 rd_data")), rd_data, exp_rd);
        chk(ta_err === fail, fail ? "R10 ta_err" : (ign && ta_bad ? "R11 ta_err" : "R13 ta_err"),
            {31'd0, ta_err}, {31'd0, fail});
        n = nrec - base_g;
        chk(n == nexp, poke ? "R2 bit count" : "R3 bit count", n, nexp);
        for (int i = 0; i < nexp && i < n && i < 256; i++) begin
            chk(rec_oe[i] === exp_oe[i] && (!exp_oe[i] || rec_o[i] === exp_o[i]),
                $sformatf("%s bit %0d", exp_tag[i], i),
                {30'd0, rec_oe[i], rec_o[i]}, {30'd0, exp_oe[i], exp_o[i]});
        end
        @(negedge clk);
        chk(!mdc && !mdio_oe && !busy && !done, "R1 idle between",
            {28'd0, mdc, mdio_oe, busy, done}, 0);
        chk(!done, "R13 done pulse width", {31'd0, done}, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(!mdc && !mdio_oe && !busy && !done, "R1 reset state",
            {28'd0, mdc, mdio_oe, busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mdc && !mdio_oe && !busy, "R1 after reset", {29'd0, mdc, mdio_oe, busy}, 0);

        // R6 R8: plain writes over every PHY number
        for (int p = 0; p < 32; p++)
            do_txn(1'b1, 1'b0, 5'(p), 21'((p * 7 + 3) % 32), 16'(p * 16'h0841) ^ 16'hA5C3,
                   1'b0, 16'h0, p == 9);
        do_txn(1'b1, 1'b0, 5'd31, 21'd31, 16'hFFFF, 1'b0, 16'h0, 1'b0);
        do_txn(1'b1, 1'b0, 5'd0, 21'd0, 16'h0000, 1'b0, 16'h0, 1'b0);

        // R9 R12: plain reads with good turnaround
        for (int p = 0; p < 16; p++)
            do_txn(1'b0, 1'b0, 5'(p * 2 + 1), 21'(p), 16'h0, 1'b0,
                   16'(p * 16'h1357 + 16'h00F0), p == 4);
        do_txn(1'b0, 1'b0, 5'd2, 21'd17, 16'h0, 1'b0, 16'h8001, 1'b0);
        do_txn(1'b0, 1'b0, 5'd2, 21'd17, 16'h0, 1'b0, 16'h7FFE, 1'b0);

        // R10: bad turnaround, not waived
        do_txn(1'b0, 1'b0, 5'd3, 21'd1, 16'h0, 1'b1, 16'h1234, 1'b0);
        do_txn(1'b0, 1'b0, 5'd17, 21'd30, 16'h0, 1'b1, 16'h0000, 1'b0);

        // R11: waived PHYs
        ta_mask = 32'h4000_0020;
        do_txn(1'b0, 1'b0, 5'd5, 21'd2, 16'h0, 1'b1, 16'hC3A5, 1'b0);
        do_txn(1'b0, 1'b0, 5'd30, 21'd9, 16'h0, 1'b1, 16'h0F0F, 1'b0);
        do_txn(1'b0, 1'b0, 5'd6, 21'd9, 16'h0, 1'b1, 16'h0F0F, 1'b0);
        do_txn(1'b0, 1'b0, 5'd5, 21'd2, 16'h0, 1'b0, 16'h5A5A, 1'b0);

        // R7: extended accesses
        do_txn(1'b1, 1'b1, 5'd1, 21'h1F_ABCD, 16'h2468, 1'b0, 16'h0, 1'b0);
        do_txn(1'b0, 1'b1, 5'd12, 21'h03_8001, 16'h0, 1'b0, 16'hBEEF, 1'b0);
        do_txn(1'b0, 1'b1, 5'd7, 21'h10_0000, 16'h0, 1'b1, 16'h1111, 1'b0);
        do_txn(1'b0, 1'b1, 5'd30, 21'h0A_FFFF, 16'h0, 1'b1, 16'h9876, 1'b1);
        do_txn(1'b1, 1'b1, 5'd0, 21'h00_0000, 16'hFFFF, 1'b0, 16'h0, 1'b1);

        report();
    end

endmodule